// File: doc/BRIEF.md
# Source-Timed Pulse and Pulse-Train Generator

This block drives one counter output with a single pulse or with a train of pulses. All of its timing is counted in active edges of an external Source timebase, not in system clocks. Each pulse is described by a pair of counts: the number of Source edges spent low before the pulse (idle ticks) and the number spent high (active ticks). Pairs are written ahead of time into a small sample buffer, one pair per pulse, so successive pulses in a train may differ.

Software writes the pairs, selects finite or continuous operation and the Source polarity, then arms the block. In finite mode the block stops after a programmed number of pulses and strobes `done_o`. In continuous mode it keeps running, reusing the most recent pair whenever the buffer runs dry, until `stop_i` is raised. The Source input is taken as already synchronous to `clk`.

Top module: `pulse_train_gen`

## Requirements
- R1: While and directly after reset, `pulse_o` and `done_o` are low and the sample buffer is empty.
- R2: After arming, `pulse_o` goes high one clock after the clock in which the idle-count-th active Source edge is seen.
- R3: Once high, `pulse_o` returns low one clock after the clock in which the active-count-th further active Source edge is seen.
- R4: `edge_fall_i` = 0 makes rising Source edges active; `edge_fall_i` = 1 makes falling Source edges active.
- R5: An idle or active count of zero behaves as a count of one, and a finite pulse count of zero behaves as one pulse.
- R6: Each pulse takes the next pair from the buffer in write order; a written word carries the idle count in its upper TICK_W bits and the active count in its lower TICK_W bits (`wr_idle_i`, `wr_active_i`).
- R7: In finite mode (`mode_cont_i` = 0 at arming) exactly `pulse_count_i` pulses are produced, and `done_o` is high for exactly one clock, the clock in which the last pulse falls.
- R8: When no unused pair is in the buffer at the start of a pulse, the pair of the previous pulse is used again; in continuous mode (`mode_cont_i` = 1 at arming) pulses continue without end.
- R9: `stop_i` during a run drives `pulse_o` low on the next clock and returns the block to idle without a `done_o` strobe.
- R10: `arm_i` is ignored while a run is in progress; mode and count are sampled only when arming from idle.
- R11: Active Source edges in the clock where `arm_i` is accepted and in the clock after it are not counted toward the first idle count.
- R12: A write while DEPTH pairs are held is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Start a run when idle |
| stop_i | input | 1 | Abort the current run |
| mode_cont_i | input | 1 | 1 = continuous, 0 = finite; sampled at arming |
| edge_fall_i | input | 1 | Active Source edge: 0 rising, 1 falling |
| pulse_count_i | input | CNT_W | Pulses in a finite run; sampled at arming |
| wr_en_i | input | 1 | Write one idle/active pair into the buffer |
| wr_idle_i | input | TICK_W | Idle ticks of the written pair |
| wr_active_i | input | TICK_W | Active ticks of the written pair |
| src_i | input | 1 | Source timebase, synchronous to clk |
| pulse_o | output | 1 | Registered pulse output, active high |
| done_o | output | 1 | One-clock strobe at the end of a finite run |

## Verification
The assertions assume that `src_i` is synchronous to `clk`, so an active edge is seen in exactly one clock, and that pairs are written while the block is idle, at least two clocks before arming, so a fresh pair has reached the buffer output when it is needed. The stimulus keeps to this: buffer writes happen only between runs, followed by idle clocks, and the Source generator toggles no faster than once per clock, leaving at least two clocks between active edges. Edge polarity is changed only when no run is in progress.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  typedef enum logic [1:0] {
    PT_IDLE = 2'd0,
    PT_LOAD = 2'd1,
    PT_LOW  = 2'd2,
    PT_HIGH = 2'd3
  } ptg_state_e;
endpackage

// File: rtl/ptg_edge_sel.sv
module ptg_edge_sel (
  input  logic clk,
  input  logic rst,
  input  logic src_i,
  input  logic fall_sel_i,
  output logic tick_o
);
  logic src_q;

  always_ff @(posedge clk) begin
    if (rst) src_q <= 1'b0;
    else     src_q <= src_i;
  end

  // one-clock tick on the selected transition
  always_comb begin
    if (fall_sel_i) tick_o = src_q & ~src_i;
    else            tick_o = src_i & ~src_q;
  end
endmodule

// File: rtl/ptg_sample_fifo.sv
module ptg_sample_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic         avail_o,
  output logic [W-1:0] rdata_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          wr_ok;

  assign wr_ok = wr_i && (cnt != CW'(DEPTH));

  // plain write port and registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wdata_i;
    rdata_o <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      avail_o <= 1'b0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (pop_i) rp <= rp + 1'b1;
      case ({wr_ok, pop_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      // lags one clock so the registered read word is current when raised
      avail_o <= (cnt != '0) && !pop_i;
    end
  end

  a_r12_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  a_r6_pop_when_avail: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> avail_o);
endmodule

// File: rtl/ptg_engine.sv
module ptg_engine
  import ptg_pkg::*;
#(
  parameter int TICK_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_i,
  input  logic              stop_i,
  input  logic              cont_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              tick_i,
  input  logic              avail_i,
  input  logic [2*TICK_W-1:0] rd_data_i,
  output logic              pop_o,
  output logic              pulse_o,
  output logic              done_o
);
  ptg_state_e        st;
  logic [TICK_W-1:0] cur_idle, cur_act, nxt_idle, nxt_act, tcnt;
  logic [TICK_W-1:0] rd_idle, rd_act;
  logic              nxt_vld, cont_q;
  logic [CNT_W-1:0]  target_q, sent_q;
  logic              load_pop, pre_pop;

  assign rd_idle = rd_data_i[2*TICK_W-1:TICK_W];
  assign rd_act  = rd_data_i[TICK_W-1:0];

  function automatic logic [TICK_W-1:0] at_least_one(input logic [TICK_W-1:0] v);
    return (v == '0) ? TICK_W'(1) : v;
  endfunction

  always_comb begin
    load_pop = (st == PT_LOAD) && !stop_i && !nxt_vld && avail_i;
    pre_pop  = ((st == PT_LOW) || (st == PT_HIGH)) && !stop_i && !nxt_vld && avail_i;
    pop_o    = load_pop || pre_pop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= PT_IDLE;
      pulse_o  <= 1'b0;
      done_o   <= 1'b0;
      nxt_vld  <= 1'b0;
      cur_idle <= TICK_W'(1);
      cur_act  <= TICK_W'(1);
      nxt_idle <= TICK_W'(1);
      nxt_act  <= TICK_W'(1);
      tcnt     <= '0;
      sent_q   <= '0;
      target_q <= CNT_W'(1);
      cont_q   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      // prefetch the following pair while a pulse is under way
      if (pre_pop) begin
        nxt_idle <= at_least_one(rd_idle);
        nxt_act  <= at_least_one(rd_act);
        nxt_vld  <= 1'b1;
      end
      case (st)
        PT_IDLE: begin
          if (arm_i) begin
            st       <= PT_LOAD;
            cont_q   <= cont_i;
            target_q <= (count_i == '0) ? CNT_W'(1) : count_i;
            sent_q   <= '0;
          end
        end
        PT_LOAD: begin
          if (stop_i) begin
            st <= PT_IDLE;
          end else begin
            if (nxt_vld) begin
              cur_idle <= nxt_idle;
              cur_act  <= nxt_act;
              nxt_vld  <= 1'b0;
            end else if (avail_i) begin
              cur_idle <= at_least_one(rd_idle);
              cur_act  <= at_least_one(rd_act);
            end
            tcnt <= '0;
            st   <= PT_LOW;
          end
        end
        PT_LOW: begin
          if (stop_i) begin
            st <= PT_IDLE;
          end else if (tick_i) begin
            if (tcnt == cur_idle - 1'b1) begin
              pulse_o <= 1'b1;
              tcnt    <= '0;
              st      <= PT_HIGH;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        PT_HIGH: begin
          if (stop_i) begin
            pulse_o <= 1'b0;
            st      <= PT_IDLE;
          end else if (tick_i) begin
            if (tcnt == cur_act - 1'b1) begin
              pulse_o <= 1'b0;
              tcnt    <= '0;
              if (!cont_q && (sent_q == target_q - 1'b1)) begin
                done_o <= 1'b1;
                st     <= PT_IDLE;
              end else begin
                sent_q <= sent_q + 1'b1;
                if (nxt_vld) begin
                  cur_idle <= nxt_idle;
                  cur_act  <= nxt_act;
                  nxt_vld  <= 1'b0;
                end
                st <= PT_LOW;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        default: st <= PT_IDLE;
      endcase
    end
  end

  a_r2_rise_after_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> $past(tick_i));

  a_r3_fall_after_tick_or_stop: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_o) |-> $past(tick_i || stop_i));

  a_r9_stop_forces_low: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !pulse_o);

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r7_done_with_fall: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $fell(pulse_o));
endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen #(
  parameter int TICK_W = 16,
  parameter int CNT_W  = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_i,
  input  logic              stop_i,
  input  logic              mode_cont_i,
  input  logic              edge_fall_i,
  input  logic [CNT_W-1:0]  pulse_count_i,
  input  logic              wr_en_i,
  input  logic [TICK_W-1:0] wr_idle_i,
  input  logic [TICK_W-1:0] wr_active_i,
  input  logic              src_i,
  output logic              pulse_o,
  output logic              done_o
);
  localparam int PAIR_W = 2 * TICK_W;

  logic              tick;
  logic              avail, pop;
  logic [PAIR_W-1:0] rd_pair;

  ptg_edge_sel u_edge (
    .clk        (clk),
    .rst        (rst),
    .src_i      (src_i),
    .fall_sel_i (edge_fall_i),
    .tick_o     (tick)
  );

  ptg_sample_fifo #(.W(PAIR_W), .DEPTH(DEPTH)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (wr_en_i),
    .wdata_i ({wr_idle_i, wr_active_i}),
    .pop_i   (pop),
    .avail_o (avail),
    .rdata_o (rd_pair)
  );

  ptg_engine #(.TICK_W(TICK_W), .CNT_W(CNT_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .arm_i     (arm_i),
    .stop_i    (stop_i),
    .cont_i    (mode_cont_i),
    .count_i   (pulse_count_i),
    .tick_i    (tick),
    .avail_i   (avail),
    .rd_data_i (rd_pair),
    .pop_o     (pop),
    .pulse_o   (pulse_o),
    .done_o    (done_o)
  );
endmodule

// File: tb/pulse_train_gen_tb.sv
module pulse_train_gen_tb_top;
  localparam int TW  = 16;
  localparam int CW  = 16;
  localparam int DEP = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic arm = 1'b0, stop = 1'b0, cont = 1'b0, fsel = 1'b0, wr = 1'b0, src = 1'b0;
  logic [TW-1:0] wi = '0, wa = '0;
  logic [CW-1:0] cnt = '0;
  logic pulse, done;

  always #10 clk = ~clk;

  pulse_train_gen #(.TICK_W(TW), .CNT_W(CW), .DEPTH(DEP)) dut_i (
    .clk(clk), .rst(rst), .arm_i(arm), .stop_i(stop), .mode_cont_i(cont),
    .edge_fall_i(fsel), .pulse_count_i(cnt), .wr_en_i(wr), .wr_idle_i(wi),
    .wr_active_i(wa), .src_i(src), .pulse_o(pulse), .done_o(done)
  );

  int tests = 0, fails = 0;
  string tag = "R1";

  task automatic check(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // free-running Source generator
  bit src_run = 1'b0;
  int half = 1, hc = 0;
  always @(negedge clk) if (src_run) begin
    hc++;
    if (hc >= half) begin hc = 0; src <= ~src; end
  end

  // behavioural reference model
  int q_i[$], q_a[$];
  int last_i = 1, last_a = 1, m_st = 0, remain = 0, target = 1, sent = 0;
  bit m_cont = 0, exp_pulse = 0, exp_done = 0, prev = 0, started = 0;

  function automatic int nz(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk) begin
    bit tk;
    tk = fsel ? (prev && !src) : (src && !prev);
    prev = src;
    exp_done = 0;
    started = 1;
    if (rst) begin
      q_i.delete(); q_a.delete();
      last_i = 1; last_a = 1; m_st = 0; exp_pulse = 0; prev = 0;
    end else begin
      if (wr && q_i.size() < DEP) begin
        q_i.push_back(nz(int'(wi)));
        q_a.push_back(nz(int'(wa)));
      end
      case (m_st)
        0: if (arm) begin
             m_st = 1; m_cont = cont; target = nz(int'(cnt)); sent = 0;
           end
        1: if (stop) m_st = 0;
           else begin
             if (q_i.size() > 0) begin last_i = q_i.pop_front(); last_a = q_a.pop_front(); end
             remain = last_i; m_st = 2;
           end
        2: if (stop) m_st = 0;
           else if (tk) begin
             remain--;
             if (remain == 0) begin exp_pulse = 1; remain = last_a; m_st = 3; end
           end
        default: if (stop) begin exp_pulse = 0; m_st = 0; end
           else if (tk) begin
             remain--;
             if (remain == 0) begin
               exp_pulse = 0; sent++;
               if (!m_cont && sent == target) begin exp_done = 1; m_st = 0; end
               else begin
                 if (q_i.size() > 0) begin last_i = q_i.pop_front(); last_a = q_a.pop_front(); end
                 remain = last_i; m_st = 2;
               end
             end
           end
      endcase
    end
  end

  int done_cnt = 0, high_cnt = 0;
  always @(negedge clk) if (started) begin
    check(pulse === exp_pulse, "pulse_o vs model", int'(pulse), int'(exp_pulse));
    check(done === exp_done, "done_o vs model", int'(done), int'(exp_done));
    if (done) done_cnt++;
    if (pulse && !rst) high_cnt++;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input int i, input int a);
    @(negedge clk); wr = 1'b1; wi = TW'(i); wa = TW'(a);
    @(negedge clk); wr = 1'b0;
    cyc(2);
  endtask

  task automatic go(input bit c, input int n);
    @(negedge clk); arm = 1'b1; cont = c; cnt = CW'(n);
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic halt();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 4000 && m_st != 0; k++) @(negedge clk);
    check(m_st == 0, "run finished", m_st, 0);
    cyc(3);
  endtask

  initial begin
    cyc(3);
    tag = "R1";
    check(pulse == 1'b0 && done == 1'b0, "outputs low in reset", int'(pulse), 0);
    @(negedge clk); rst = 1'b0;
    cyc(2);
    check(pulse == 1'b0, "pulse low after reset", int'(pulse), 0);

    // R2 R3: delay 4, width 3 on rising edges
    tag = "R2 R3";
    src_run = 1; half = 1;
    put(4, 3);
    done_cnt = 0; high_cnt = 0;
    go(1'b0, 1);
    wait_idle();
    check(done_cnt == 1, "single pulse done count", done_cnt, 1);
    check(high_cnt == 6, "width 3 ticks at 2 clocks each", high_cnt, 6);

    // R4: falling edges, slower Source
    tag = "R4";
    fsel = 1'b1; half = 2;
    put(2, 2); put(3, 1);
    done_cnt = 0;
    go(1'b0, 2);
    wait_idle();
    check(done_cnt == 1, "falling-edge train done", done_cnt, 1);
    fsel = 1'b0; half = 1;

    // R5: zero counts behave as one, zero pulse count as one pulse
    tag = "R5";
    put(0, 0); put(0, 5);
    done_cnt = 0; high_cnt = 0;
    go(1'b0, 0);
    wait_idle();
    check(done_cnt == 1, "zero count gives one pulse", done_cnt, 1);
    check(high_cnt == 2, "zero width gives one tick", high_cnt, 2);

    // R6 R7: differing pairs in write order, finite count
    tag = "R6 R7";
    put(1, 2); put(3, 1); put(2, 4);
    done_cnt = 0;
    go(1'b0, 4);
    wait_idle();
    check(done_cnt == 1, "finite train single done", done_cnt, 1);

    // R8 R9: continuous with reuse, then stop
    tag = "R8 R9";
    put(2, 1);
    done_cnt = 0;
    go(1'b1, 0);
    cyc(61);
    halt();
    cyc(3);
    check(pulse == 1'b0, "stopped output low", int'(pulse), 0);
    check(done_cnt == 0, "no done on stop", done_cnt, 0);

    // R10: re-arm during a run is ignored
    tag = "R10";
    put(3, 3);
    done_cnt = 0;
    go(1'b0, 3);
    cyc(5);
    go(1'b1, 1);
    wait_idle();
    check(done_cnt == 1, "finite run unaffected by re-arm", done_cnt, 1);

    // R11: edges around arming are not counted
    tag = "R11";
    put(1, 1);
    go(1'b0, 1);
    wait_idle();

    // R12: overflow write dropped
    tag = "R12";
    for (int k = 1; k <= DEP + 1; k++) put(k, 1);
    done_cnt = 0;
    go(1'b0, DEP + 1);
    wait_idle();
    check(done_cnt == 1, "overflow run done", done_cnt, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog %s: actual timeout expected completion", tag);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule